// File: doc/BRIEF.md
# SDRAM Power-Up Command Issuer

This block sits between a simple host access port and the command, address and bank pins of a single-data-rate SDRAM. A three-bit mode register, loaded by software, decides what the next host access does. In normal mode an access passes through as a plain read or write command on the SDRAM bus. In every other mode the access is turned into one fixed SDRAM command, whatever its direction. The possible commands are no-operation, precharge of all banks, mode-register load, extended mode-register load, auto-refresh and deep power-down.

Software uses it to walk a memory device through its power-up sequence one step at a time. It writes a mode and then makes one dummy access, and the block puts exactly one command on the bus. The host is then held off with a ready signal until the recovery time of that command has passed. The block also guards against an auto-refresh issued before any precharge-all. It parks the clock-enable pin low once a deep power-down has been sent.

Top module: `sdinit_cmd_issuer`

## Requirements
- R1: After reset the bus idles with the no-operation encoding {cs_n,ras_n,cas_n,we_n} = 0111, address and bank zero, clock enable high, host ready high, error low and the mode register at 0 (normal).
- R2: An access accepted on a rising edge (host_req and host_rdy both high) puts its command on the bus for exactly the following clock cycle, and the bus returns to no-operation afterwards. Mode codes map as follows: 1 gives no-operation 0111, 2 gives precharge-all 0010, 3 and 5 give mode load 0000, 4 gives auto-refresh 0001 and 6 gives deep power-down 0110. Reads and writes alike produce the command.
- R3: Writing the mode register puts nothing on the bus. The new value governs only the accesses accepted after the write edge.
- R4: An access in mode 4 with no precharge-all issued since reset, or since the last deep power-down, sends no-operation instead of auto-refresh. In that case host_err is high for that one command cycle and the host is not stalled.
- R5: A mode-load command (mode 3) drives host_addr onto the address pins with bank 0. An extended mode-load (mode 5) drives host_addr and the access's own bank number.
- R6: After a mode-load or extended mode-load, host_rdy is low for exactly cfg_lmr_wait cycles, counted from the command cycle. A value of 0 means no stall.
- R7: Precharge-all drives address bit 10 high with all other address bits and the bank zero, and stalls for TRP_CYC cycles. Auto-refresh drives address and bank zero and stalls for TRFC_CYC cycles.
- R8: In mode 0, a write access issues 0100 and a read access issues 0101, each carrying host_addr and host_bank, with no stall.
- R9: Mode code 7 behaves as mode 1: every access issues no-operation with address and bank zero.
- R10: Clock enable falls in the same cycle as a deep power-down command. It stays low until a mode write of a value other than 6, and is high again from the cycle after that write.
- R11: A request presented while host_rdy is low is not taken. No command appears on the bus for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_wr | input | 1 | Mode register write strobe |
| mode_wdata | input | 3 | Mode value to write |
| cfg_lmr_wait | input | CNT_W | Cycles to stall after a mode-load command |
| host_req | input | 1 | Host access request |
| host_we | input | 1 | Access direction, 1 = write |
| host_bank | input | BA_W | Access bank number |
| host_addr | input | ADDR_W | Access address |
| host_rdy | output | 1 | High when an access can be accepted |
| host_err | output | 1 | Refresh refused, no prior precharge-all |
| sd_cke | output | 1 | SDRAM clock enable |
| sd_cs_n | output | 1 | SDRAM chip select, active low |
| sd_ras_n | output | 1 | SDRAM row strobe, active low |
| sd_cas_n | output | 1 | SDRAM column strobe, active low |
| sd_we_n | output | 1 | SDRAM write enable, active low |
| sd_addr | output | ADDR_W | SDRAM address pins |
| sd_ba | output | BA_W | SDRAM bank pins |

## Verification
The assertions check several rules on every cycle. The bus is never non-idle without an accepted access, and it stays quiet while the host is stalled. A refresh goes out only after a remembered precharge-all, and an error flag only ever rides on a no-operation. Clock enable falls only with a deep power-down. The stall counter counts down by one each cycle, and the mode holds between writes. The exact command, address and bank for each mode, the stall length for each command and the clock-enable wake-up after a later mode write all depend on mode history. The bench's scoreboard scenarios show these.

// File: rtl/sdinit_pkg.sv
package sdinit_pkg;

    // Mode register values: software picks what the next access becomes.
    typedef enum logic [2:0] {
        MD_NORMAL = 3'd0,
        MD_NOP    = 3'd1,
        MD_PALL   = 3'd2,
        MD_LMR    = 3'd3,
        MD_REF    = 3'd4,
        MD_ELMR   = 3'd5,
        MD_DPD    = 3'd6,
        MD_RSVD   = 3'd7
    } mode_e;

    // SDR command pins, packed as {cs_n, ras_n, cas_n, we_n}.
    typedef enum logic [3:0] {
        CMD_LMR   = 4'b0000,
        CMD_REF   = 4'b0001,
        CMD_PALL  = 4'b0010,
        CMD_WRITE = 4'b0100,
        CMD_READ  = 4'b0101,
        CMD_DPD   = 4'b0110,
        CMD_NOP   = 4'b0111
    } cmd_e;

    // Address pin that selects "all banks" on a precharge.
    localparam int ALLBANK_BIT = 10;

endpackage

// File: rtl/sdinit_mode_reg.sv
module sdinit_mode_reg
    import sdinit_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [2:0] wr_val,
    input  logic       dpd_issue,
    output mode_e      mode,
    output logic       cke
);

    typedef struct packed {
        mode_e mode;
        logic  cke;
    } mreg_t;

    mreg_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_en) begin
            s_d.mode = mode_e'(wr_val);
        end
        // A power-down issue wins over a concurrent wake-up write.
        if (dpd_issue) begin
            s_d.cke = 1'b0;
        end else if (wr_en && (wr_val != MD_DPD)) begin
            s_d.cke = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{mode: MD_NORMAL, cke: 1'b1};
        end else begin
            s_q <= s_d;
        end
    end

    assign mode = s_q.mode;
    assign cke  = s_q.cke;

    // R3: mode only moves on a write
    p_mode_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(s_q.mode));

    // R10: a non-power-down write wakes the clock enable
    p_cke_wake_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_val != MD_DPD) && !dpd_issue) |=> s_q.cke);

endmodule

// File: rtl/sdinit_cmd_decode.sv
module sdinit_cmd_decode
    import sdinit_pkg::*;
#(
    parameter int ADDR_W   = 13,
    parameter int BA_W     = 2,
    parameter int CNT_W    = 4,
    parameter int TRP_CYC  = 3,
    parameter int TRFC_CYC = 7
) (
    input  mode_e              mode,
    input  logic               acc_we,
    input  logic [BA_W-1:0]    acc_bank,
    input  logic [ADDR_W-1:0]  acc_addr,
    input  logic               pall_seen,
    input  logic [CNT_W-1:0]   tmrd,
    output cmd_e               cmd,
    output logic [ADDR_W-1:0]  addr,
    output logic [BA_W-1:0]    ba,
    output logic [CNT_W-1:0]   delay,
    output logic               blocked
);

    localparam logic [CNT_W-1:0] TRP_L  = CNT_W'(TRP_CYC);
    localparam logic [CNT_W-1:0] TRFC_L = CNT_W'(TRFC_CYC);

    // Address pattern for precharge-all: only the all-bank pin set.
    logic [ADDR_W-1:0] pall_addr;
    for (genvar g = 0; g < ADDR_W; g++) begin : g_pall_addr
        assign pall_addr[g] = (g == ALLBANK_BIT);
    end

    typedef struct packed {
        cmd_e              cmd;
        logic [ADDR_W-1:0] addr;
        logic [BA_W-1:0]   ba;
        logic [CNT_W-1:0]  delay;
        logic              blocked;
    } dec_t;

    dec_t dec;

    always_comb begin
        dec = '{cmd: CMD_NOP, addr: '0, ba: '0, delay: '0, blocked: 1'b0};
        unique case (mode)
            MD_NORMAL: begin
                dec.cmd  = acc_we ? CMD_WRITE : CMD_READ;
                dec.addr = acc_addr;
                dec.ba   = acc_bank;
            end
            MD_PALL: begin
                dec.cmd   = CMD_PALL;
                dec.addr  = pall_addr;
                dec.delay = TRP_L;
            end
            MD_LMR: begin
                dec.cmd   = CMD_LMR;
                dec.addr  = acc_addr;
                dec.delay = tmrd;
            end
            MD_ELMR: begin
                dec.cmd   = CMD_LMR;
                dec.addr  = acc_addr;
                dec.ba    = acc_bank;
                dec.delay = tmrd;
            end
            MD_REF: begin
                if (pall_seen) begin
                    dec.cmd   = CMD_REF;
                    dec.delay = TRFC_L;
                end else begin
                    dec.blocked = 1'b1;
                end
            end
            MD_DPD: begin
                dec.cmd = CMD_DPD;
            end
            default: begin
                dec.cmd = CMD_NOP;
            end
        endcase
    end

    assign cmd     = dec.cmd;
    assign addr    = dec.addr;
    assign ba      = dec.ba;
    assign delay   = dec.delay;
    assign blocked = dec.blocked;

endmodule

// File: rtl/sdinit_recovery_timer.sv
module sdinit_recovery_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             busy
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (load) begin
            s_d.cnt = load_val;
        end else if (s_q.cnt != '0) begin
            s_d.cnt = s_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{cnt: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign busy = (s_q.cnt != '0);

    // R6: a running wait counts down by exactly one per cycle
    p_count_down_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.cnt != '0) |=> (s_q.cnt == $past(s_q.cnt) - 1'b1));

    // R11: no new wait is loaded while one is running
    p_no_reload_r11: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (s_q.cnt == '0));

endmodule

// File: rtl/sdinit_cmd_issuer.sv
module sdinit_cmd_issuer
    import sdinit_pkg::*;
#(
    parameter int ADDR_W   = 13,
    parameter int BA_W     = 2,
    parameter int CNT_W    = 4,
    parameter int TRP_CYC  = 3,
    parameter int TRFC_CYC = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_wr,
    input  logic [2:0]        mode_wdata,
    input  logic [CNT_W-1:0]  cfg_lmr_wait,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [BA_W-1:0]   host_bank,
    input  logic [ADDR_W-1:0] host_addr,
    output logic              host_rdy,
    output logic              host_err,
    output logic              sd_cke,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [ADDR_W-1:0] sd_addr,
    output logic [BA_W-1:0]   sd_ba
);

    mode_e             cur_mode;
    cmd_e              dec_cmd;
    logic [ADDR_W-1:0] dec_addr;
    logic [BA_W-1:0]   dec_ba;
    logic [CNT_W-1:0]  dec_delay;
    logic              dec_blocked;
    logic              busy;
    logic              acc;
    logic              dpd_issue;

    typedef struct packed {
        cmd_e              cmd;
        logic [ADDR_W-1:0] addr;
        logic [BA_W-1:0]   ba;
        logic              err;
        logic              pall_seen;
    } bus_t;

    bus_t s_d, s_q;

    assign host_rdy  = !busy;
    assign acc       = host_req && host_rdy;
    assign dpd_issue = acc && (dec_cmd == CMD_DPD);

    sdinit_mode_reg i_mode_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (mode_wr),
        .wr_val    (mode_wdata),
        .dpd_issue (dpd_issue),
        .mode      (cur_mode),
        .cke       (sd_cke)
    );

    sdinit_cmd_decode #(
        .ADDR_W   (ADDR_W),
        .BA_W     (BA_W),
        .CNT_W    (CNT_W),
        .TRP_CYC  (TRP_CYC),
        .TRFC_CYC (TRFC_CYC)
    ) i_decode (
        .mode      (cur_mode),
        .acc_we    (host_we),
        .acc_bank  (host_bank),
        .acc_addr  (host_addr),
        .pall_seen (s_q.pall_seen),
        .tmrd      (cfg_lmr_wait),
        .cmd       (dec_cmd),
        .addr      (dec_addr),
        .ba        (dec_ba),
        .delay     (dec_delay),
        .blocked   (dec_blocked)
    );

    sdinit_recovery_timer #(
        .CNT_W (CNT_W)
    ) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (acc),
        .load_val (dec_delay),
        .busy     (busy)
    );

    always_comb begin
        s_d      = s_q;
        s_d.cmd  = CMD_NOP;
        s_d.addr = '0;
        s_d.ba   = '0;
        s_d.err  = 1'b0;
        if (acc) begin
            s_d.cmd  = dec_cmd;
            s_d.addr = dec_addr;
            s_d.ba   = dec_ba;
            s_d.err  = dec_blocked;
            if (dec_cmd == CMD_PALL) begin
                s_d.pall_seen = 1'b1;
            end else if (dec_cmd == CMD_DPD) begin
                s_d.pall_seen = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{cmd: CMD_NOP, addr: '0, ba: '0, err: 1'b0, pall_seen: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = s_q.cmd;
    assign sd_addr  = s_q.addr;
    assign sd_ba    = s_q.ba;
    assign host_err = s_q.err;

    // R2: a non-idle command only follows an accepted access
    p_cmd_needs_access_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.cmd != CMD_NOP) |-> $past(acc));

    // R11: a stalled cycle is followed by an idle bus
    p_quiet_when_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !host_rdy |=> (s_q.cmd == CMD_NOP));

    // R4: refresh only after a remembered precharge-all
    p_ref_after_pall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.cmd == CMD_REF) |-> $past(s_q.pall_seen));

    // R4: a refused refresh leaves the bus idle
    p_err_on_nop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        host_err |-> (s_q.cmd == CMD_NOP));

    // R10: clock enable drops only alongside deep power-down
    p_cke_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sd_cke) |-> (s_q.cmd == CMD_DPD));

    // R7: precharge-all always carries the all-bank pin
    p_pall_allbank_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.cmd == CMD_PALL) |-> sd_addr[ALLBANK_BIT]);

endmodule

// File: tb/test_sdinit_cmd_issuer.sv
module test_sdinit_cmd_issuer;

    localparam int ADDR_W = 13;
    localparam int BA_W   = 2;
    localparam int CNT_W  = 4;
    localparam int TRP    = 3;
    localparam int TRFC   = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_wr = 1'b0;
    logic [2:0] mode_wdata = '0;
    logic [CNT_W-1:0] cfg_lmr_wait = 4'd2;
    logic host_req = 1'b0;
    logic host_we = 1'b0;
    logic [BA_W-1:0] host_bank = '0;
    logic [ADDR_W-1:0] host_addr = '0;
    logic host_rdy, host_err, sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
    logic [ADDR_W-1:0] sd_addr;
    logic [BA_W-1:0] sd_ba;

    always #4 clk = ~clk;

    sdinit_cmd_issuer #(
        .ADDR_W(ADDR_W), .BA_W(BA_W), .CNT_W(CNT_W), .TRP_CYC(TRP), .TRFC_CYC(TRFC)
    ) i_sdinit_cmd_issuer (
        .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
        .cfg_lmr_wait(cfg_lmr_wait), .host_req(host_req), .host_we(host_we),
        .host_bank(host_bank), .host_addr(host_addr), .host_rdy(host_rdy),
        .host_err(host_err), .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
        .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_addr(sd_addr), .sd_ba(sd_ba)
    );

    typedef struct {
        logic [3:0]        cmd;
        logic [ADDR_W-1:0] addr;
        logic [BA_W-1:0]   ba;
        logic              err;
        int                stall;
        string             tag;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   fails  = 0;
    bit   done   = 1'b0;
    bit   acc_flag = 1'b0;

    // Bench model state, kept from the requirements
    bit [2:0] m_mode = 3'd0;
    bit       m_pall = 1'b0;

    task automatic chk(bit ok, string tag, string act, string exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%s expected=%s", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] bus_cmd();
        return {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
    endfunction

    function automatic exp_t predict(bit we, logic [BA_W-1:0] bank, logic [ADDR_W-1:0] addr);
        exp_t e;
        e.cmd = 4'b0111; e.addr = '0; e.ba = '0; e.err = 1'b0; e.stall = 0; e.tag = "";
        case (m_mode)
            3'd0: begin e.cmd = we ? 4'b0100 : 4'b0101; e.addr = addr; e.ba = bank; end
            3'd2: begin e.cmd = 4'b0010; e.addr = 13'h400; e.stall = TRP; m_pall = 1'b1; end
            3'd3: begin e.cmd = 4'b0000; e.addr = addr; e.stall = int'(cfg_lmr_wait); end
            3'd4: begin
                if (m_pall) begin e.cmd = 4'b0001; e.stall = TRFC; end
                else e.err = 1'b1;
            end
            3'd5: begin e.cmd = 4'b0000; e.addr = addr; e.ba = bank; e.stall = int'(cfg_lmr_wait); end
            3'd6: begin e.cmd = 4'b0110; m_pall = 1'b0; end
            default: ;
        endcase
        return e;
    endfunction

    // Monitor: record acceptance at the edge, compare at the following falling edge
    always @(posedge clk) acc_flag <= rst_n && host_req && host_rdy;

    always @(negedge clk) begin : mon
        exp_t e;
        if (rst_n && !done) begin
            if (acc_flag) begin
                if (q.size() == 0) begin
                    chk(1'b0, "R2 unexpected access", "cmd", "none");
                end else begin
                    e = q.pop_front();
                    chk(bus_cmd() == e.cmd && sd_addr == e.addr && sd_ba == e.ba && host_err == e.err,
                        e.tag,
                        $sformatf("cmd=%b addr=%h ba=%0d err=%0b", bus_cmd(), sd_addr, sd_ba, host_err),
                        $sformatf("cmd=%b addr=%h ba=%0d err=%0b", e.cmd, e.addr, e.ba, e.err));
                end
            end else if (bus_cmd() != 4'b0111 || host_err) begin
                chk(1'b0, "R11/R3 bus not idle", $sformatf("cmd=%b err=%0b", bus_cmd(), host_err), "cmd=0111 err=0");
            end
        end
    end

    task automatic set_mode(bit [2:0] v);
        @(negedge clk);
        mode_wr = 1'b1; mode_wdata = v;
        @(negedge clk);
        mode_wr = 1'b0;
        m_mode = v;
    endtask

    task automatic access(bit we, logic [BA_W-1:0] bank, logic [ADDR_W-1:0] addr, string tag);
        exp_t e;
        int n;
        @(negedge clk);
        while (!host_rdy) @(negedge clk);
        e = predict(we, bank, addr);
        e.tag = tag;
        q.push_back(e);
        host_req = 1'b1; host_we = we; host_bank = bank; host_addr = addr;
        @(negedge clk);
        host_req = 1'b0;
        n = 0;
        while (!host_rdy) begin n++; @(negedge clk); end
        chk(n == e.stall, {tag, " stall"}, $sformatf("%0d", n), $sformatf("%0d", e.stall));
    endtask

    task automatic summary();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=running expected=finished");
            summary();
        end
    end

    initial begin : main
        int m;
        repeat (3) @(negedge clk);
        // R1: idle state during and right after reset
        chk(bus_cmd() == 4'b0111 && sd_addr == '0 && sd_ba == '0 && sd_cke && host_rdy && !host_err,
            "R1 reset", $sformatf("cmd=%b cke=%0b rdy=%0b", bus_cmd(), sd_cke, host_rdy), "cmd=0111 cke=1 rdy=1");
        rst_n = 1'b1;
        @(negedge clk);
        chk(bus_cmd() == 4'b0111 && sd_cke && host_rdy && !host_err, "R1 after release",
            $sformatf("cmd=%b cke=%0b rdy=%0b", bus_cmd(), sd_cke, host_rdy), "cmd=0111 cke=1 rdy=1");

        // R8: default normal mode, read and write pass through
        access(1'b0, 2'd2, 13'h0123, "R8 read");
        access(1'b1, 2'd1, 13'h1ABC, "R8 write");
        access(1'b1, 2'd3, 13'h0001, "R8 back-to-back write");

        // R3: a mode write alone leaves the bus idle; next access uses it
        set_mode(3'd1);
        repeat (2) @(negedge clk);
        chk(bus_cmd() == 4'b0111, "R3 write only", $sformatf("%b", bus_cmd()), "0111");
        access(1'b0, 2'd2, 13'h0555, "R2 nop read");
        access(1'b1, 2'd3, 13'h0AAA, "R2 nop write");

        // R4: refresh before any precharge-all is refused
        set_mode(3'd4);
        access(1'b1, 2'd0, 13'h0000, "R4 refused refresh");

        // R7: precharge-all then refresh
        set_mode(3'd2);
        access(1'b0, 2'd3, 13'h1FFF, "R7 precharge-all");
        set_mode(3'd4);
        access(1'b0, 2'd1, 13'h0777, "R7 refresh read");
        access(1'b1, 2'd2, 13'h0100, "R7 refresh write");

        // R5/R6: mode load with a stall of 5, requests held while stalled (R11)
        cfg_lmr_wait = 4'd5;
        set_mode(3'd3);
        @(negedge clk);
        begin : lmr_hold
            exp_t e;
            e = predict(1'b0, 2'd1, 13'h0031);
            e.tag = "R5 mode load bank 0";
            q.push_back(e);
            host_req = 1'b1; host_we = 1'b0; host_bank = 2'd1; host_addr = 13'h0031;
            @(negedge clk);
            host_addr = 13'h00AA;
            m = 1;
            for (int k = 0; k < 3; k++) begin
                @(negedge clk);
                chk(!host_rdy && bus_cmd() == 4'b0111, "R11 held request",
                    $sformatf("rdy=%0b cmd=%b", host_rdy, bus_cmd()), "rdy=0 cmd=0111");
                m++;
            end
            host_req = 1'b0;
            @(negedge clk);
            while (!host_rdy) begin m++; @(negedge clk); end
            chk(m == 5, "R6 mode load stall", $sformatf("%0d", m), "5");
        end
        cfg_lmr_wait = 4'd0;
        access(1'b1, 2'd2, 13'h0022, "R6 zero wait");
        cfg_lmr_wait = 4'd15;
        access(1'b1, 2'd0, 13'h0033, "R6 max wait");

        // R5: extended load carries the access bank
        cfg_lmr_wait = 4'd2;
        set_mode(3'd5);
        access(1'b1, 2'd1, 13'h0020, "R5 extended load");

        // R9: reserved code behaves as no-operation
        set_mode(3'd7);
        access(1'b0, 2'd3, 13'h0F0F, "R9 code 7");

        // R10: deep power-down and clock enable
        set_mode(3'd6);
        chk(sd_cke == 1'b1, "R10 cke before access", $sformatf("%0b", sd_cke), "1");
        access(1'b0, 2'd0, 13'h0000, "R10 deep power-down");
        chk(sd_cke == 1'b0, "R10 cke at command", $sformatf("%0b", sd_cke), "0");
        repeat (3) @(negedge clk);
        chk(sd_cke == 1'b0, "R10 cke held", $sformatf("%0b", sd_cke), "0");
        set_mode(3'd6);
        chk(sd_cke == 1'b0, "R10 same-mode write", $sformatf("%0b", sd_cke), "0");
        set_mode(3'd1);
        chk(sd_cke == 1'b1, "R10 wake on mode change", $sformatf("%0b", sd_cke), "1");

        // R4: power-down forgets the earlier precharge-all
        set_mode(3'd4);
        access(1'b0, 2'd0, 13'h0000, "R4 refused after power-down");

        set_mode(3'd0);
        access(1'b0, 2'd1, 13'h0444, "R8 normal again");

        repeat (3) @(negedge clk);
        chk(q.size() == 0, "R2 all accesses seen", $sformatf("%0d", q.size()), "0");
        summary();
    end

endmodule